// File: doc/BRIEF.md
# Delayed-Read PCI Target Controller

This block sits behind a PCI interface core that has already claimed a target access. From the bar-hit flags, one local address bit and the bus command, it decides which local resource the access is for: the large, slow memory behind a data FIFO pair, the small register file, or the write-only descriptor queue. It then drives the local target handshake that completes, retries or disconnects the access, and it issues the pop, push and flush strobes for the data FIFOs.

The slow memory needs more than 16 clocks to return its first word, so memory reads are handled as delayed transactions. The first read to an address is retried at once. At the same time a one-cycle prefetch request is sent to the memory side, carrying that address. While the read FIFO fills, every memory access is retried, but register accesses still complete. When the read FIFO reaches its threshold, the next read to the same address completes and streams data until frame is released. Whatever is left in the read FIFO is then flushed. Memory writes stream into the write FIFO. After a write ends, memory accesses are retried until the memory side has drained that FIFO.

Top module: `delayed_tgt_ctrl`

## Requirements
- R1: Window select. `barHit == 2'b10` selects memory. `barHit == 2'b01` selects registers when `addrIn[19]` is 0 and the descriptor queue when it is 1. Any other `barHit` value is disconnected without ready. Read commands are 4'b0110, 4'b1100 and 4'b1110. Write commands are 4'b0111 and 4'b1111. Any other command is disconnected without ready and starts no prefetch.
- R2: A memory read is retried when no prefetch is held and no write drain is pending. Retried means `tgtDisc` is high and `tgtReady` is low in the cycle after the edge that samples `tgtFrame` high. In that same cycle `memRdReq` pulses for exactly one cycle, and `memRdAddr` equals the address of the access.
- R3: While a prefetch is filling, every memory read and write is retried and no new prefetch starts. A prefetch is filling while `rdLevel` has not yet reached `RD_THRESH` (default 32).
- R4: While a prefetch is held, a memory read to a different address is retried, does not pulse `memRdReq`, and leaves `memRdAddr` unchanged.
- R5: Once `rdLevel >= RD_THRESH` has been seen, a memory read to the held address gets `tgtReady`. `rdPop` is high in each cycle that `xferDone` is high, until `tgtFrame` falls.
- R6: While read data streams, `tgtDisc` is high whenever `rdLevel < LOW_WATER` (default 4).
- R7: After a streaming read ends, `rdFlush` pulses for one cycle, one cycle after the edge that samples `tgtFrame` low. The held prefetch is then dropped, so the next memory read starts a new prefetch.
- R8: A memory write, with no prefetch held and no drain pending, gets `tgtReady`. `wrPush` is high in each cycle that `xferDone` is high. `tgtDisc` is high whenever `wrLevel >= WR_ALMOST` (default 124).
- R9: After a memory write ends, every memory access is retried and starts no prefetch until `wrLevel == 0` and `memWrBusy` is low.
- R10: A register access raises `tgtReady` and `tgtDisc` together (one data phase), with `regWr` or `regRd` pulsing per `xferDone` according to direction. A descriptor-queue write gets `tgtReady` without `tgtDisc` and `descPush` per `xferDone`, so bursts are allowed. A descriptor-queue read is retried.
- R11: After reset every output is low, no prefetch is held and no drain is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tgtFrame | input | 1 | High while the core presents a claimed target access |
| xferDone | input | 1 | A local data phase completed in this cycle |
| barHit | input | 2 | Bar-hit flags: bit 0 register/descriptor space, bit 1 memory |
| addrIn | input | 32 | Local byte address of the access |
| cmdIn | input | 4 | PCI bus command |
| rdLevel | input | 8 | Read FIFO fill level in words |
| wrLevel | input | 8 | Write FIFO fill level in words |
| memWrBusy | input | 1 | Memory side still writing drained data |
| tgtReady | output | 1 | Local target ready |
| tgtDisc | output | 1 | Retry or disconnect request |
| rdPop | output | 1 | Pop one word from the read FIFO |
| wrPush | output | 1 | Push one word into the write FIFO |
| descPush | output | 1 | Push one word into the descriptor queue |
| regWr | output | 1 | Register write strobe |
| regRd | output | 1 | Register read strobe |
| rdFlush | output | 1 | Flush the read FIFO |
| memRdReq | output | 1 | One-cycle prefetch request to the memory side |
| memRdAddr | output | 32 | Address of the held prefetch |

## Verification
The embedded properties check on every cycle that a filling prefetch or a pending write drain forces any memory access into retry. They also check that streaming only happens from a ready prefetch, that the end of a streaming read flushes the FIFO and drops the prefetch, that a prefetch request is a single pulse, that no request is raised while a prefetch is held, and that streaming below the low-water mark disconnects. Only the bench scenarios can show the full delayed-read round trip: retry, fill, matching re-read, then flush and a fresh prefetch on the next read. The same holds for mismatched-address retries that leave the held address unchanged, for the release of the drain once the FIFO empties and the memory side goes idle, and for burst counts on the descriptor queue.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {WIN_NONE, WIN_MEM, WIN_REG, WIN_DESC} win_e;
  typedef enum logic [1:0] {CMD_OTHER, CMD_READ, CMD_WRITE} cmd_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RETRY, ST_MRD, ST_MWR, ST_REG, ST_DESC} tst_e;
  typedef enum logic [1:0] {PF_NONE, PF_FILL, PF_READY} pf_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;
    logic streamRd;
    logic streamWr;
    logic regPhase;
    logic regWrite;
    logic descPhase;
    logic retryPhase;
    logic flushPulse;
    logic reqPulse;
  } ctl_strobe_t;

  // level and address flags from datapath to control
  typedef struct packed {
    logic addrMatch;
    logic fillDone;
    logic wrIdle;
  } dp_flag_t;

endpackage

// File: rtl/dtc_decode.sv
module dtc_decode
  import dtc_pkg::*;
(
  input  logic [1:0] barHit,
  input  logic       selBit,
  input  logic [3:0] cmdIn,
  output win_e       win,
  output cmd_e       cmdKind
);

  always_comb begin
    unique case (barHit)
      2'b10:   win = WIN_MEM;
      2'b01:   win = selBit ? WIN_DESC : WIN_REG;
      default: win = WIN_NONE;
    endcase
  end

  always_comb begin
    unique case (cmdIn)
      4'b0110, 4'b1100, 4'b1110: cmdKind = CMD_READ;
      4'b0111, 4'b1111:          cmdKind = CMD_WRITE;
      default:                   cmdKind = CMD_OTHER;
    endcase
  end

endmodule

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tgtFrame,
  input  win_e        win,
  input  cmd_e        cmdKind,
  input  dp_flag_t    flags,
  output ctl_strobe_t strb
);

  tst_e state, nextSt;
  pf_e  pfState;
  logic drainPend;
  logic startPf;
  logic reqQ, flushQ, regWriteQ;

  logic frameStart;
  assign frameStart = (state == ST_IDLE) && tgtFrame;

  always_comb begin
    nextSt  = state;
    startPf = 1'b0;
    if (state == ST_IDLE) begin
      if (tgtFrame) begin
        nextSt = ST_RETRY;
        unique case (win)
          WIN_MEM: begin
            if (cmdKind == CMD_READ) begin
              if (drainPend) begin
                nextSt = ST_RETRY;
              end else if (pfState == PF_NONE) begin
                startPf = 1'b1;
              end else if (pfState == PF_READY && flags.addrMatch) begin
                nextSt = ST_MRD;
              end
            end else if (cmdKind == CMD_WRITE) begin
              if (!drainPend && pfState == PF_NONE) nextSt = ST_MWR;
            end
          end
          WIN_REG:  if (cmdKind != CMD_OTHER) nextSt = ST_REG;
          WIN_DESC: if (cmdKind == CMD_WRITE) nextSt = ST_DESC;
          default:  nextSt = ST_RETRY;
        endcase
      end
    end else if (!tgtFrame) begin
      nextSt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pfState   <= PF_NONE;
      drainPend <= 1'b0;
      reqQ      <= 1'b0;
      flushQ    <= 1'b0;
      regWriteQ <= 1'b0;
    end else begin
      state  <= nextSt;
      reqQ   <= startPf;
      flushQ <= (state == ST_MRD) && !tgtFrame;
      if (frameStart) regWriteQ <= (cmdKind == CMD_WRITE);

      if (startPf)                                pfState <= PF_FILL;
      else if (state == ST_MRD && !tgtFrame)      pfState <= PF_NONE;
      else if (pfState == PF_FILL && flags.fillDone) pfState <= PF_READY;

      if (state == ST_MWR && !tgtFrame)           drainPend <= 1'b1;
      else if (drainPend && flags.wrIdle)         drainPend <= 1'b0;
    end
  end

  always_comb begin
    strb.capAddr    = startPf;
    strb.streamRd   = (state == ST_MRD);
    strb.streamWr   = (state == ST_MWR);
    strb.regPhase   = (state == ST_REG);
    strb.regWrite   = regWriteQ;
    strb.descPhase  = (state == ST_DESC);
    strb.retryPhase = (state == ST_RETRY);
    strb.flushPulse = flushQ;
    strb.reqPulse   = reqQ;
  end

  // R3
  fill_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && win == WIN_MEM && pfState == PF_FILL) |=> (state == ST_RETRY));

  // R9
  drain_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && win == WIN_MEM && drainPend) |=> (state == ST_RETRY && !reqQ));

  // R5
  stream_from_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MRD) |-> (pfState == PF_READY));

  // R7
  flush_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MRD && !tgtFrame) |=> (flushQ && pfState == PF_NONE));

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |=> !reqQ);

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pfState != PF_NONE) |=> !reqQ);

endmodule

// File: rtl/dtc_dpath.sv
module dtc_dpath
  import dtc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 8,
  parameter int RD_THRESH = 32,
  parameter int LOW_WATER = 4,
  parameter int WR_ALMOST = 124
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tgtFrame,
  input  logic              xferDone,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LVL_W-1:0]  rdLevel,
  input  logic [LVL_W-1:0]  wrLevel,
  input  logic              memWrBusy,
  input  ctl_strobe_t       strb,
  output dp_flag_t          flags,
  output logic              tgtReady,
  output logic              tgtDisc,
  output logic              rdPop,
  output logic              wrPush,
  output logic              descPush,
  output logic              regWr,
  output logic              regRd,
  output logic              rdFlush,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr
);

  localparam logic [LVL_W-1:0] THR_L  = LVL_W'(RD_THRESH);
  localparam logic [LVL_W-1:0] LOW_L  = LVL_W'(LOW_WATER);
  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(WR_ALMOST);

  logic [ADDR_W-1:0] pfAddr;
  logic lowWater, nearFull;

  always_ff @(posedge clk) begin
    if (!rstN)             pfAddr <= '0;
    else if (strb.capAddr) pfAddr <= addrIn;
  end

  assign lowWater        = rdLevel < LOW_L;
  assign nearFull        = wrLevel >= FULL_L;
  assign flags.addrMatch = (addrIn == pfAddr);
  assign flags.fillDone  = rdLevel >= THR_L;
  assign flags.wrIdle    = (wrLevel == '0) && !memWrBusy;

  assign tgtReady = tgtFrame &&
    (strb.streamRd || strb.streamWr || strb.regPhase || strb.descPhase);
  assign tgtDisc  = tgtFrame &&
    (strb.retryPhase || strb.regPhase ||
     (strb.streamRd && lowWater) || (strb.streamWr && nearFull));

  assign rdPop     = strb.streamRd  && xferDone;
  assign wrPush    = strb.streamWr  && xferDone;
  assign descPush  = strb.descPhase && xferDone;
  assign regWr     = strb.regPhase  && xferDone &&  strb.regWrite;
  assign regRd     = strb.regPhase  && xferDone && !strb.regWrite;
  assign rdFlush   = strb.flushPulse;
  assign memRdReq  = strb.reqPulse;
  assign memRdAddr = pfAddr;

  // R6
  low_water_disc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtFrame && rdPop && rdLevel < LOW_L) |-> tgtDisc);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capAddr) |=> $stable(memRdAddr));

  // R10
  one_phase_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr || regRd) |-> (tgtDisc && !rdPop && !wrPush && !descPush));

endmodule

// File: rtl/delayed_tgt_ctrl.sv
module delayed_tgt_ctrl
  import dtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_BIT    = 19,
  parameter int FIFO_DEPTH = 128,
  parameter int RD_THRESH  = 32,
  parameter int LOW_WATER  = 4,
  parameter int WR_ALMOST  = 124,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tgtFrame,
  input  logic              xferDone,
  input  logic [1:0]        barHit,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [3:0]        cmdIn,
  input  logic [LVL_W-1:0]  rdLevel,
  input  logic [LVL_W-1:0]  wrLevel,
  input  logic              memWrBusy,
  output logic              tgtReady,
  output logic              tgtDisc,
  output logic              rdPop,
  output logic              wrPush,
  output logic              descPush,
  output logic              regWr,
  output logic              regRd,
  output logic              rdFlush,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr
);

  win_e        win;
  cmd_e        cmdKind;
  ctl_strobe_t strb;
  dp_flag_t    flags;

  dtc_decode u_decode (
    .barHit (barHit),
    .selBit (addrIn[SEL_BIT]),
    .cmdIn  (cmdIn),
    .win    (win),
    .cmdKind(cmdKind)
  );

  dtc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tgtFrame(tgtFrame),
    .win     (win),
    .cmdKind (cmdKind),
    .flags   (flags),
    .strb    (strb)
  );

  dtc_dpath #(
    .ADDR_W   (ADDR_W),
    .LVL_W    (LVL_W),
    .RD_THRESH(RD_THRESH),
    .LOW_WATER(LOW_WATER),
    .WR_ALMOST(WR_ALMOST)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .tgtFrame (tgtFrame),
    .xferDone (xferDone),
    .addrIn   (addrIn),
    .rdLevel  (rdLevel),
    .wrLevel  (wrLevel),
    .memWrBusy(memWrBusy),
    .strb     (strb),
    .flags    (flags),
    .tgtReady (tgtReady),
    .tgtDisc  (tgtDisc),
    .rdPop    (rdPop),
    .wrPush   (wrPush),
    .descPush (descPush),
    .regWr    (regWr),
    .regRd    (regRd),
    .rdFlush  (rdFlush),
    .memRdReq (memRdReq),
    .memRdAddr(memRdAddr)
  );

endmodule

// File: tb/delayed_tgt_ctrl_tb.sv
module delayed_tgt_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tgtFrame = 1'b0, xferDone = 1'b0, memWrBusy = 1'b0;
  logic [1:0]  barHit = 2'b00;
  logic [31:0] addrIn = '0;
  logic [3:0]  cmdIn = '0;
  logic [7:0]  rdLevel = '0, wrLevel = '0;
  logic tgtReady, tgtDisc, rdPop, wrPush, descPush, regWr, regRd, rdFlush, memRdReq;
  logic [31:0] memRdAddr;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  delayed_tgt_ctrl u_dut (
    .clk(clk), .rstN(rstN), .tgtFrame(tgtFrame), .xferDone(xferDone),
    .barHit(barHit), .addrIn(addrIn), .cmdIn(cmdIn), .rdLevel(rdLevel),
    .wrLevel(wrLevel), .memWrBusy(memWrBusy), .tgtReady(tgtReady),
    .tgtDisc(tgtDisc), .rdPop(rdPop), .wrPush(wrPush), .descPush(descPush),
    .regWr(regWr), .regRd(regRd), .rdFlush(rdFlush), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr)
  );

  // expected-state model (from the requirements)
  localparam int K_RETRY = 0, K_MRD = 1, K_MWR = 2, K_REG = 3, K_DESC = 4;
  int          mPf = 0;       // 0 none, 1 filling, 2 ready
  logic [31:0] mPfAddr = '0;
  bit          mDrain = 1'b0;

  task automatic check(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int isRead(logic [3:0] c);
    return (c == 4'b0110 || c == 4'b1100 || c == 4'b1110) ? 1 : 0;
  endfunction
  function automatic int isWrite(logic [3:0] c);
    return (c == 4'b0111 || c == 4'b1111) ? 1 : 0;
  endfunction

  function automatic int decide(logic [1:0] b, logic [31:0] a, logic [3:0] c, output bit startPf);
    startPf = 1'b0;
    if (b == 2'b10) begin                         // R1 memory window
      if (isRead(c) != 0) begin
        if (mDrain) return K_RETRY;               // R9
        if (mPf == 0) begin startPf = 1'b1; return K_RETRY; end  // R2
        if (mPf == 2 && a == mPfAddr) return K_MRD;              // R5
        return K_RETRY;                           // R3 R4
      end
      if (isWrite(c) != 0 && !mDrain && mPf == 0) return K_MWR; // R8
      return K_RETRY;
    end
    if (b == 2'b01 && !a[19]) return (isRead(c) != 0 || isWrite(c) != 0) ? K_REG : K_RETRY;
    if (b == 2'b01 && a[19])  return (isWrite(c) != 0) ? K_DESC : K_RETRY;
    return K_RETRY;
  endfunction

  function automatic void settle();
    if (mPf == 1 && rdLevel >= 8'd32) mPf = 2;
    if (mDrain && wrLevel == 0 && !memWrBusy) mDrain = 1'b0;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setLevels(logic [7:0] r, logic [7:0] w, logic busy);
    rdLevel = r; wrLevel = w; memWrBusy = busy;
    idle(2);
    settle();
  endtask

  // one claimed access, compared against the model
  task automatic op(string tag, logic [1:0] b, logic [31:0] a, logic [3:0] c, int nx);
    bit sp;
    int k;
    logic r0, d0, q0, fl;
    int pops = 0, pushes = 0, descs = 0, rw = 0, rr = 0;
    logic [31:0] oldAddr;
    oldAddr = memRdAddr;
    k = decide(b, a, c, sp);
    @(negedge clk);
    barHit = b; addrIn = a; cmdIn = c; tgtFrame = 1'b1;
    @(negedge clk);
    r0 = tgtReady; d0 = tgtDisc; q0 = memRdReq;
    check(tag, "ready", r0, (k != K_RETRY) ? 1 : 0);
    check(tag, "disc", d0, (k == K_RETRY || k == K_REG ||
                            (k == K_MRD && rdLevel < 4) || (k == K_MWR && wrLevel >= 124)) ? 1 : 0);
    check(tag, "memRdReq", q0, sp ? 1 : 0);
    check(tag, "memRdAddr", memRdAddr, sp ? a : oldAddr);
    for (int i = 0; i < nx; i++) begin
      xferDone = 1'b1;
      #1;
      pops += rdPop; pushes += wrPush; descs += descPush; rw += regWr; rr += regRd;
      @(negedge clk);
    end
    xferDone = 1'b0; tgtFrame = 1'b0;
    @(negedge clk);
    fl = rdFlush;
    check(tag, "pops", pops, (k == K_MRD) ? nx : 0);
    check(tag, "pushes", pushes, (k == K_MWR) ? nx : 0);
    check(tag, "descPush", descs, (k == K_DESC) ? nx : 0);
    check(tag, "regWr", rw, (k == K_REG && isWrite(c) != 0) ? nx : 0);
    check(tag, "regRd", rr, (k == K_REG && isRead(c) != 0) ? nx : 0);
    check(tag, "flush", fl, (k == K_MRD) ? 1 : 0);
    @(negedge clk);
    check(tag, "flushOnce", rdFlush, 0);
    if (sp) begin mPf = 1; mPfAddr = a; end
    if (k == K_MRD) mPf = 0;
    if (k == K_MWR) mDrain = 1'b1;
    idle(1);
    settle();
  endtask

  localparam logic [31:0] A_MEM = 32'h0012_3440;
  localparam logic [31:0] B_MEM = 32'h0012_3480;

  initial begin : watchdog
    #2_000_000ns;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] cmds [7];
    cmds = '{4'b0110, 4'b1100, 4'b1110, 4'b0111, 4'b1111, 4'b0010, 4'b0011};
    void'($urandom(32'd4242));
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "outputs", {tgtReady, tgtDisc, rdPop, wrPush, descPush, regWr, regRd,
                              rdFlush, memRdReq}, 0);
    check("R11", "memRdAddr", memRdAddr, 0);

    // R10 register and descriptor windows
    op("R10", 2'b01, 32'h0000_0008, 4'b0111, 1);
    op("R10", 2'b01, 32'h0000_0004, 4'b0110, 1);
    op("R10", 2'b01, 32'h0008_0000, 4'b0111, 3);
    op("R10", 2'b01, 32'h0008_0010, 4'b0110, 1);
    // R1 unsupported command and bad bar flags
    op("R1", 2'b10, A_MEM, 4'b0010, 1);
    op("R1", 2'b11, A_MEM, 4'b0110, 1);
    op("R1", 2'b00, A_MEM, 4'b0111, 1);
    // R2 first read starts prefetch
    setLevels(8'd0, 8'd0, 1'b0);
    op("R2", 2'b10, A_MEM, 4'b0110, 1);
    check("R2", "memRdAddr", memRdAddr, A_MEM);
    // R3 filling: memory retried, registers served
    setLevels(8'd20, 8'd0, 1'b0);
    op("R3", 2'b10, A_MEM, 4'b1100, 1);
    op("R3", 2'b10, A_MEM, 4'b0111, 1);
    op("R3", 2'b01, 32'h0000_000c, 4'b0110, 1);
    // R4 mismatched address
    op("R4", 2'b10, B_MEM, 4'b0110, 1);
    check("R4", "heldAddr", memRdAddr, A_MEM);
    // R5 and R7 threshold met, stream, flush
    setLevels(8'd40, 8'd0, 1'b0);
    op("R5", 2'b10, A_MEM, 4'b0110, 5);
    op("R7", 2'b10, A_MEM, 4'b0110, 1);
    // R6 low water disconnect while streaming
    setLevels(8'd40, 8'd0, 1'b0);
    setLevels(8'd2, 8'd0, 1'b0);
    op("R6", 2'b10, A_MEM, 4'b0110, 2);
    // R8 write near full, then R9 drain hold
    setLevels(8'd0, 8'd124, 1'b0);
    op("R8", 2'b10, B_MEM, 4'b0111, 4);
    op("R9", 2'b10, B_MEM, 4'b0110, 1);
    setLevels(8'd0, 8'd0, 1'b1);
    op("R9", 2'b10, B_MEM, 4'b0111, 1);
    setLevels(8'd0, 8'd0, 1'b0);
    op("R9", 2'b10, B_MEM, 4'b0110, 1);
    setLevels(8'd64, 8'd0, 1'b0);
    op("R8", 2'b10, B_MEM, 4'b0110, 3);
    setLevels(8'd0, 8'd10, 1'b0);
    op("R8", 2'b10, A_MEM, 4'b1111, 4);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] rl, wl;
      logic [1:0] b;
      logic [31:0] a;
      int sel;
      if ($urandom_range(0, 2) == 0) begin
        sel = $urandom_range(0, 4);
        rl = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd2 : (sel == 2) ? 8'd20 :
             (sel == 3) ? 8'd40 : 8'd100;
        sel = $urandom_range(0, 2);
        wl = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd10 : 8'd124;
        setLevels(rl, wl, ($urandom_range(0, 3) == 0));
      end
      sel = $urandom_range(0, 9);
      b = (sel < 6) ? 2'b10 : (sel < 9) ? 2'b01 : 2'(sel);
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? A_MEM : (sel == 1) ? B_MEM :
          (sel == 2) ? 32'h0008_0000 : {$urandom()} & 32'h000F_FFFC;
      op("R1", b, a, cmds[$urandom_range(0, 6)], $urandom_range(1, 4));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule